// File: doc/BRIEF.md
# Unaligned Bit-Span Framebuffer Writer

This block places a run of up to sixteen distinct pixels into a one-bit-per-pixel video memory at any bit position. The memory is organised in 16-bit words. A pixel run that starts partway into a word spills its remaining pixels into the next word. Each pixel lives in two planes. The visibility plane says whether the pixel is shown. The colour plane says whether it is light or dark. Both planes are read, merged and written back with one bit mask, which is derived from the pattern.

A command names a word index, a bit offset inside that word, a 16-bit pattern, a level value and a buffer select (front or back). The block takes the command only while it is idle. It then runs one or two read-modify-write passes over a synchronous memory port that carries both planes side by side. It raises a one-cycle completion pulse after the last write. Pixels are numbered from the most significant bit of a word, so pixel 0 is the leftmost pixel.

Top module: `span_writer`

## Requirements
- R1: During and after reset, with no command taken, `cmd_ready` is 1 and `mem_rd`, `mem_wr` and `done` are 0.
- R2: Bit positions count from the most significant bit, which is position 0. Pattern bit k (k=0 is the MSB) lands at position offset+k of the two-word run formed by the addressed word followed by the next word.
- R3: In the visibility plane, every one bit of the placed pattern is set. Every other bit of the touched words keeps its old value.
- R4: In the colour plane, the bits under the placed pattern's one bits become 1 when `cmd_level` is 1 and become 0 when it is 0. Every other bit keeps its old value.
- R5: With offset 0, exactly one read and one write are issued, both at the addressed word. The following word is left unchanged.
- R6: With a nonzero offset, a second read-modify-write is issued at word index plus one in the same buffer. This happens even when the spilled bits are all zero, and in that case the word keeps its value.
- R7: `mem_addr` carries `cmd_buf` in its most significant bit and the word index below it. The other buffer is never modified.
- R8: `cmd_ready` is 0 from the cycle after a command is taken until the completion pulse. A command offered during that time is ignored and has no effect on memory.
- R9: `mem_rd` is high in the first cycle after acceptance. The completion pulse `done` is high for exactly one cycle, 4 cycles after acceptance for a one-word command and 7 cycles after it for a two-word command.
- R10: Read data is taken from `vis_rdata`/`lvl_rdata` one cycle after the `mem_rd` cycle. The write to the same address follows one cycle later, and a read and a write are never issued together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken when valid |
| cmd_addr | input | 12 | Word index of the first word |
| cmd_offset | input | 4 | Starting bit position, 0 = MSB |
| cmd_pattern | input | 16 | Pixel pattern, MSB first |
| cmd_level | input | 1 | Colour value written under pattern ones |
| cmd_buf | input | 1 | Buffer select (0 front, 1 back) |
| mem_addr | output | 13 | {buffer, word index} |
| mem_rd | output | 1 | Read strobe, data due next cycle |
| mem_wr | output | 1 | Write strobe for both planes |
| vis_rdata | input | 16 | Visibility plane read data |
| lvl_rdata | input | 16 | Colour plane read data |
| vis_wdata | output | 16 | Visibility plane write data |
| lvl_wdata | output | 16 | Colour plane write data |
| done | output | 1 | One-cycle completion pulse |

## Verification
Counted from the accepting edge, the read strobe is visible one cycle later. The merged write follows two cycles after the read, and `done` arrives at cycle 4 for one word or cycle 7 for two. The bench counts falling edges after acceptance and checks that `done` appears exactly at the expected count and is gone one cycle later. It compares the complete memory image only after `done`, when every write has landed. While the block is busy, the bench offers conflicting commands and checks `cmd_ready` at each falling edge. Writes per command are counted so that a missing or extra second pass is reported.

// File: rtl/span_pkg.sv
package span_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_MERGE = 2'd2,
    ST_WRITE = 2'd3
  } span_state_e;
endpackage

// File: rtl/span_shifter.sv
// Places the pattern into a two-word window, MSB = position 0.
module span_shifter #(
  parameter int DW = 16,
  localparam int OW = $clog2(DW)
) (
  input  logic [DW-1:0] pattern,
  input  logic [OW-1:0] offset,
  input  logic          second,
  output logic [DW-1:0] bits,
  output logic          spills
);
  logic [2*DW-1:0] window;

  always_comb begin
    window = {pattern, {DW{1'b0}}} >> offset;
    bits   = second ? window[DW-1:0] : window[2*DW-1:DW];
    spills = (offset != '0);
  end
endmodule

// File: rtl/plane_merge.sv
// Merges placed pattern bits into one plane word; variant chosen by COLOUR.
module plane_merge #(
  parameter int DW     = 16,
  parameter bit COLOUR = 1'b0
) (
  input  logic [DW-1:0] old_word,
  input  logic [DW-1:0] bits,
  input  logic          level,
  output logic [DW-1:0] new_word
);
  generate
    if (COLOUR) begin : g_colour
      always_comb new_word = level ? (old_word | bits) : (old_word & ~bits);
    end else begin : g_visible
      logic unused_level;
      always_comb begin
        unused_level = level;
        new_word     = old_word | bits;
      end
    end
  endgenerate
endmodule

// File: rtl/span_writer.sv
module span_writer #(
  parameter int DW    = 16,
  parameter int WORDS = 3072,
  localparam int AW = $clog2(WORDS),
  localparam int OW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_addr,
  input  logic [OW-1:0] cmd_offset,
  input  logic [DW-1:0] cmd_pattern,
  input  logic          cmd_level,
  input  logic          cmd_buf,
  output logic [AW:0]   mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  input  logic [DW-1:0] vis_rdata,
  input  logic [DW-1:0] lvl_rdata,
  output logic [DW-1:0] vis_wdata,
  output logic [DW-1:0] lvl_wdata,
  output logic          done
);
  import span_pkg::*;

  span_state_e   state;
  logic [DW-1:0] pat_q;
  logic [OW-1:0] ofs_q;
  logic          lvl_q;
  logic          second_q;
  logic [DW-1:0] placed;
  logic          spills;
  logic [DW-1:0] vis_new;
  logic [DW-1:0] lvl_new;

  span_shifter #(.DW(DW)) shifter_i (
    .pattern (pat_q),
    .offset  (ofs_q),
    .second  (second_q),
    .bits    (placed),
    .spills  (spills)
  );

  plane_merge #(.DW(DW), .COLOUR(1'b0)) vis_merge_i (
    .old_word (vis_rdata),
    .bits     (placed),
    .level    (lvl_q),
    .new_word (vis_new)
  );

  plane_merge #(.DW(DW), .COLOUR(1'b1)) lvl_merge_i (
    .old_word (lvl_rdata),
    .bits     (placed),
    .level    (lvl_q),
    .new_word (lvl_new)
  );

  assign cmd_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pat_q     <= '0;
      ofs_q     <= '0;
      lvl_q     <= 1'b0;
      second_q  <= 1'b0;
      mem_addr  <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      vis_wdata <= '0;
      lvl_wdata <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            pat_q    <= cmd_pattern;
            ofs_q    <= cmd_offset;
            lvl_q    <= cmd_level;
            second_q <= 1'b0;
            mem_addr <= {cmd_buf, cmd_addr};
            mem_rd   <= 1'b1;
            state    <= ST_READ;
          end
        end
        ST_READ: begin
          mem_rd <= 1'b0;
          state  <= ST_MERGE;
        end
        ST_MERGE: begin
          mem_wr    <= 1'b1;
          vis_wdata <= vis_new;
          lvl_wdata <= lvl_new;
          state     <= ST_WRITE;
        end
        ST_WRITE: begin
          mem_wr <= 1'b0;
          if (!second_q && spills) begin
            second_q         <= 1'b1;
            mem_addr[AW-1:0] <= mem_addr[AW-1:0] + 1'b1;
            mem_rd           <= 1'b1;
            state            <= ST_READ;
          end else begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |-> !cmd_ready); // R8
  AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R10
  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_wr) |-> $past(mem_rd, 2) && (mem_addr == $past(mem_addr, 2))); // R10
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(mem_wr) && cmd_ready); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_NEXT_WORD: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && $past(mem_wr)) |->
      (mem_addr[AW-1:0] == AW'($past(mem_addr[AW-1:0]) + 1'b1)) &&
      (mem_addr[AW] == $past(mem_addr[AW]))); // R6
endmodule

// File: tb/span_writer_tb_top.sv
module span_writer_tb_top;
  localparam int DW = 16;
  localparam int AW = 12;
  localparam int OW = 4;
  localparam int MD = 128;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic [OW-1:0] cmd_offset = '0;
  logic [DW-1:0] cmd_pattern = '0;
  logic          cmd_level = 1'b0;
  logic          cmd_buf = 1'b0;
  logic [AW:0]   mem_addr;
  logic          mem_rd, mem_wr, done;
  logic [DW-1:0] vis_rdata, lvl_rdata, vis_wdata, lvl_wdata;

  logic [DW-1:0] vis_mem [MD];
  logic [DW-1:0] lvl_mem [MD];
  logic [DW-1:0] vis_exp [MD];
  logic [DW-1:0] lvl_exp [MD];

  int checks = 0;
  int failures = 0;
  int wr_count = 0;
  int rd_count = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  span_writer dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_offset(cmd_offset), .cmd_pattern(cmd_pattern),
    .cmd_level(cmd_level), .cmd_buf(cmd_buf), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .vis_rdata(vis_rdata),
    .lvl_rdata(lvl_rdata), .vis_wdata(vis_wdata), .lvl_wdata(lvl_wdata),
    .done(done)
  );

  function automatic int midx(input logic b, input logic [AW-1:0] a);
    return {b, a[5:0]};
  endfunction

  function automatic logic [DW-1:0] fill(input int i, input int plane);
    return DW'(i * 16'h9E37 ^ (plane ? 16'hA55A : 16'h3C96));
  endfunction

  // Bench memory model: synchronous read, one-cycle latency.
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MD; i++) begin
        vis_mem[i] <= fill(i, 0);
        lvl_mem[i] <= fill(i, 1);
      end
    end else begin
      if (mem_rd) begin
        vis_rdata <= vis_mem[midx(mem_addr[AW], mem_addr[AW-1:0])];
        lvl_rdata <= lvl_mem[midx(mem_addr[AW], mem_addr[AW-1:0])];
        rd_count  <= rd_count + 1;
      end
      if (mem_wr) begin
        vis_mem[midx(mem_addr[AW], mem_addr[AW-1:0])] <= vis_wdata;
        lvl_mem[midx(mem_addr[AW], mem_addr[AW-1:0])] <= lvl_wdata;
        wr_count <= wr_count + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_update(input logic [AW-1:0] a, input logic [OW-1:0] o,
                              input logic [DW-1:0] p, input logic l, input logic b);
    logic [2*DW-1:0] w;
    logic [DW-1:0] part;
    w = {p, {DW{1'b0}}} >> o;
    for (int k = 0; k < 2; k++) begin
      if (k == 1 && o == 0) break;
      part = (k == 0) ? w[2*DW-1:DW] : w[DW-1:0];
      vis_exp[midx(b, AW'(a + k))] = vis_exp[midx(b, AW'(a + k))] | part;
      lvl_exp[midx(b, AW'(a + k))] = l ? (lvl_exp[midx(b, AW'(a + k))] | part)
                                       : (lvl_exp[midx(b, AW'(a + k))] & ~part);
    end
  endtask

  task automatic compare_mem(input string req);
    int bad = 0;
    for (int i = 0; i < MD; i++) begin
      if (bad == 0 && (vis_mem[i] !== vis_exp[i] || lvl_mem[i] !== lvl_exp[i])) begin
        bad = 1;
        $display("FAIL %s memory word %0d vis actual=%0h expected=%0h lvl actual=%0h expected=%0h",
                 req, i, vis_mem[i], vis_exp[i], lvl_mem[i], lvl_exp[i]);
      end
    end
    checks++;
    if (bad != 0) failures++;
  endtask

  // Issue one command; optionally offer a conflicting command while busy.
  task automatic run_cmd(input logic [AW-1:0] a, input logic [OW-1:0] o,
                         input logic [DW-1:0] p, input logic l, input logic b,
                         input bit poke, input string req);
    int cyc = 0;
    int exp_cyc;
    int wr0;
    int rd0;
    bit ready_ok = 1'b1;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    wr0 = wr_count;
    rd0 = rd_count;
    cmd_addr = a; cmd_offset = o; cmd_pattern = p; cmd_level = l; cmd_buf = b;
    cmd_valid = 1'b1;
    @(negedge clk);
    cyc = 1;
    check(mem_rd === 1'b1, "R9", "read strobe one cycle after accept", mem_rd, 1);
    if (poke) begin
      cmd_addr = AW'(a + 1); cmd_offset = ~o; cmd_pattern = ~p; cmd_level = ~l; cmd_buf = ~b;
    end else begin
      cmd_valid = 1'b0;
    end
    while (!done && cyc < 20) begin
      if (cmd_ready) ready_ok = 1'b0;
      @(negedge clk);
      cyc++;
    end
    cmd_valid = 1'b0;
    exp_cyc = (o == 0) ? 4 : 7;
    check(ready_ok, "R8", "ready stayed low while busy", ready_ok, 1);
    check(cyc == exp_cyc, "R9", "done cycle after accept", cyc, exp_cyc);
    @(negedge clk);
    check(done === 1'b0, "R9", "done lasts one cycle", done, 0);
    check(wr_count - wr0 == ((o == 0) ? 1 : 2), (o == 0) ? "R5" : "R6",
          "write count", wr_count - wr0, (o == 0) ? 1 : 2);
    check(rd_count - rd0 == ((o == 0) ? 1 : 2), "R10", "read count",
          rd_count - rd0, (o == 0) ? 1 : 2);
    model_update(a, o, p, l, b);
    compare_mem(req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < MD; i++) begin
      vis_exp[i] = fill(i, 0);
      lvl_exp[i] = fill(i, 1);
    end
    repeat (3) @(negedge clk);
    // R1: reset values
    check(cmd_ready === 1'b1, "R1", "ready in reset", cmd_ready, 1);
    check(mem_rd === 1'b0 && mem_wr === 1'b0, "R1", "strobes in reset", {mem_rd, mem_wr}, 0);
    check(done === 1'b0, "R1", "done in reset", done, 0);
    rst = 1'b0;
    @(negedge clk);
    check(cmd_ready === 1'b1 && done === 1'b0, "R1", "idle after reset", {cmd_ready, done}, 2);

    // R2 R3 R4: worked example, offset 5 straddling a boundary
    run_cmd(12'd10, 4'd5, 16'hFAFF, 1'b1, 1'b0, 1'b0, "R2");
    // R4: clearing colour under pattern
    run_cmd(12'd20, 4'd9, 16'hF0F0, 1'b0, 1'b0, 1'b0, "R4");
    // R5: offset 0, next word untouched
    run_cmd(12'd30, 4'd0, 16'h8001, 1'b1, 1'b1, 1'b0, "R5");
    // R6: spill bits all zero still accesses next word, value kept
    run_cmd(12'd40, 4'd4, 16'hFFF0, 1'b0, 1'b1, 1'b0, "R6");
    // R6: maximum offset
    run_cmd(12'd50, 4'd15, 16'hFFFF, 1'b1, 1'b0, 1'b0, "R6");
    // R7: back buffer, front buffer shadow must stay intact
    run_cmd(12'd3070, 4'd3, 16'h5A5A, 1'b1, 1'b1, 1'b0, "R7");
    // R8: conflicting command offered while busy is ignored
    run_cmd(12'd15, 4'd7, 16'h1234, 1'b0, 1'b0, 1'b1, "R8");
    run_cmd(12'd16, 4'd0, 16'hABCD, 1'b1, 1'b1, 1'b1, "R8");
    // R3 R4 random mix
    for (int n = 0; n < 60; n++) begin
      run_cmd(AW'($urandom_range(0, 62)), OW'($urandom()), DW'($urandom()),
              1'($urandom()), 1'($urandom()), 1'($urandom_range(0, 3) == 0), "R3");
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule